// File: doc/BRIEF.md
# Byte-Wide Timer Host Register Interface

This block is the bus-facing front end of a bank of three 16-bit counter channels. A host reaches it through a simple synchronous byte bus: a 3-bit address, a write byte with a write strobe, and a read byte with a read strobe. Addresses 1, 3 and 5 are the data ports of channels 0, 1 and 2. Address 7 is the command port. A command byte either reprograms one channel, setting its transfer format, mode and BCD flag, or it takes a snapshot of that channel's live count for a later read.

For each channel the block sequences the one-byte or two-byte transfers that the programmed format calls for. Each channel has its own write byte-order flip-flop and its own read byte-order flip-flop. The block assembles 16-bit load values and hands them to the counter core with a one-cycle load strobe. It shows the mode and BCD setting of each channel on plain outputs, together with a one-cycle mode-set strobe. The counting itself happens outside this block, and the live counts come back on an input bus.

The bus has no back-pressure. Every write or read strobe is accepted in the cycle in which it is asserted. Read data is combinational from the current state and is valid in the cycle of the read strobe. The side effects of a read (advancing the byte order and releasing a latch) take place at the clock edge that ends that cycle.

Top module: `timer_host_if`

## Requirements
- R1: Data ports sit at addresses 1, 3 and 5 for channels 0, 1 and 2, and the command port sits at address 7. A write to any other address changes nothing, and a read from any other address returns 0x00.
- R2: The command byte is laid out as bits 7:6 channel select, bits 5:4 transfer format, bits 3:1 mode and bit 0 BCD flag. A select value of 3 has no effect on any channel.
- R3: A command with a nonzero format reprograms the selected channel. One cycle after the write, its mode and BCD outputs show the new fields and its mode-set strobe is high for exactly one cycle. Both byte-order flip-flops return to the first byte, and any pending latch is dropped.
- R4: A command with format 0 captures the selected channel's live count at the write edge. It leaves the mode, BCD and format unchanged and raises no mode-set strobe. A second latch command while a latch is still pending is ignored.
- R5: With format 1, a data write loads {0x00, byte}. The load value and a one-cycle load strobe appear one cycle after the write.
- R6: With format 2, a data write loads {byte, 0x00}, so that writing 0x01 loads 256.
- R7: With format 3, the first data write is the low byte and gives no strobe. The second is the high byte and produces the 16-bit load and its strobe one cycle later.
- R8: Reads return the low byte in format 1 and the high byte in format 2. In format 3 they alternate low then high, starting from low.
- R9: A latched value is what reads return until it has been read completely in the programmed format. After that, reads return the live count again.
- R10: After reset every channel is in format 3, mode 0 and BCD 0, with no strobes and no pending latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Relative byte address |
| bus_wdata | input | 8 | Write byte |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read byte, valid in the cycle of bus_re |
| chan_count | input | 48 | Live counts, channel i at bits 16i+15:16i |
| chan_load_val | output | 48 | Assembled load values, channel i at bits 16i+15:16i |
| chan_load_stb | output | 3 | One-cycle load strobe per channel |
| chan_mode | output | 9 | Mode per channel, channel i at bits 3i+2:3i |
| chan_bcd | output | 3 | BCD flag per channel |
| chan_mode_set | output | 3 | One-cycle reprogram strobe per channel |

## Verification
A byte-order flip-flop left in the wrong state shows up at the next two-byte transfer on that channel. A write produces either a premature load strobe or a load value with its halves swapped, one cycle after the write. A read returns the high byte where the low byte was due, in the same cycle as the read strobe. A latch that is not held, or not released, gives read data that follows the changing live count, or stays frozen after the second byte. Because the bench moves the live counts on every cycle, this appears at the very next read.

// File: rtl/timer_host_pkg.sv
package timer_host_pkg;
  typedef enum logic [1:0] {
    FMT_LATCH = 2'd0,
    FMT_LSB   = 2'd1,
    FMT_MSB   = 2'd2,
    FMT_BOTH  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] fmt;
    logic [2:0] mode;
    logic       bcd;
  } cmd_t;
endpackage

// File: rtl/timer_cmd_decode.sv
module timer_cmd_decode
  import timer_host_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic           cmd_we,
  input  logic [7:0]     cmd_byte,
  output logic [NCH-1:0] prog,
  output logic [NCH-1:0] latch,
  output logic [1:0]     fmt,
  output logic [2:0]     mode,
  output logic           bcd
);
  cmd_t c;
  assign c    = cmd_t'(cmd_byte);
  assign fmt  = c.fmt;
  assign mode = c.mode;
  assign bcd  = c.bcd;

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    logic hit;
    assign hit      = cmd_we && (int'(c.sel) == i);
    assign prog[i]  = hit && (c.fmt != FMT_LATCH);
    assign latch[i] = hit && (c.fmt == FMT_LATCH);
  end
endmodule

// File: rtl/timer_chan_port.sv
module timer_chan_port
  import timer_host_pkg::*;
#(
  parameter int BW = 8,
  parameter int MW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog,
  input  logic            latch_cmd,
  input  logic [1:0]      cmd_fmt,
  input  logic [MW-1:0]   cmd_mode,
  input  logic            cmd_bcd,
  input  logic            data_we,
  input  logic            data_re,
  input  logic [BW-1:0]   wdata,
  input  logic [2*BW-1:0] live,
  output logic [BW-1:0]   rd_byte,
  output logic [2*BW-1:0] load_val,
  output logic            load_stb,
  output logic [MW-1:0]   mode,
  output logic            bcd,
  output logic            mode_set
);
  localparam int CW = 2 * BW;

  logic [1:0]    fmt_q;
  logic          wr_hi, rd_hi, lat_vld;
  logic [BW-1:0] lo_hold;
  logic [CW-1:0] lat_q, src;

  assign src = lat_vld ? lat_q : live;

  always_comb begin
    case (fmt_q)
      FMT_LSB: rd_byte = src[BW-1:0];
      FMT_MSB: rd_byte = src[CW-1 -: BW];
      default: rd_byte = rd_hi ? src[CW-1 -: BW] : src[BW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q    <= FMT_BOTH;
      mode     <= '0;
      bcd      <= 1'b0;
      wr_hi    <= 1'b0;
      rd_hi    <= 1'b0;
      lat_vld  <= 1'b0;
      lat_q    <= '0;
      lo_hold  <= '0;
      load_val <= '0;
      load_stb <= 1'b0;
      mode_set <= 1'b0;
    end else begin
      load_stb <= 1'b0;
      mode_set <= 1'b0;
      if (prog) begin
        fmt_q    <= cmd_fmt;
        mode     <= cmd_mode;
        bcd      <= cmd_bcd;
        wr_hi    <= 1'b0;
        rd_hi    <= 1'b0;
        lat_vld  <= 1'b0;
        mode_set <= 1'b1;
      end else if (latch_cmd && !lat_vld) begin
        lat_q   <= live;
        lat_vld <= 1'b1;
      end
      if (data_we && !prog) begin
        case (fmt_q)
          FMT_LSB: begin load_val <= {{BW{1'b0}}, wdata}; load_stb <= 1'b1; end
          FMT_MSB: begin load_val <= {wdata, {BW{1'b0}}}; load_stb <= 1'b1; end
          default: begin
            if (!wr_hi) begin
              lo_hold <= wdata;
              wr_hi   <= 1'b1;
            end else begin
              load_val <= {wdata, lo_hold};
              load_stb <= 1'b1;
              wr_hi    <= 1'b0;
            end
          end
        endcase
      end
      if (data_re && !prog && !latch_cmd) begin
        if (fmt_q == FMT_BOTH) rd_hi <= !rd_hi;
        if (fmt_q != FMT_BOTH || rd_hi) lat_vld <= 1'b0;
      end
    end
  end

  // R3
  mode_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set |-> $past(prog));

  // R5
  load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(data_we));

  // R7
  first_byte_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !prog && fmt_q == FMT_BOTH && !wr_hi) |=> !load_stb);

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_vld && $past(lat_vld)) |-> $stable(lat_q));
endmodule

// File: rtl/timer_host_if.sv
module timer_host_if #(
  parameter int NCH = 3,
  parameter int BW  = 8,
  parameter int MW  = 3,
  parameter int AW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BW-1:0]     bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [BW-1:0]     bus_rdata,
  input  logic [NCH*2*BW-1:0] chan_count,
  output logic [NCH*2*BW-1:0] chan_load_val,
  output logic [NCH-1:0]    chan_load_stb,
  output logic [NCH*MW-1:0] chan_mode,
  output logic [NCH-1:0]    chan_bcd,
  output logic [NCH-1:0]    chan_mode_set
);
  localparam int CW = 2 * BW;
  localparam logic [AW-1:0] CMD_ADDR = AW'(2 * NCH + 1);

  logic [NCH-1:0]  prog, latch;
  logic [1:0]      fmt;
  logic [2:0]      cmode;
  logic            cbcd;
  logic [BW-1:0]   rd_bytes [NCH];
  logic [NCH-1:0]  hit;

  timer_cmd_decode #(.NCH(NCH)) u_dec (
    .cmd_we  (bus_we && bus_addr == CMD_ADDR),
    .cmd_byte(bus_wdata),
    .prog    (prog),
    .latch   (latch),
    .fmt     (fmt),
    .mode    (cmode),
    .bcd     (cbcd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i] = (bus_addr == AW'(2 * i + 1));
    timer_chan_port #(.BW(BW), .MW(MW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog     (prog[i]),
      .latch_cmd(latch[i]),
      .cmd_fmt  (fmt),
      .cmd_mode (MW'(cmode)),
      .cmd_bcd  (cbcd),
      .data_we  (bus_we && hit[i]),
      .data_re  (bus_re && hit[i]),
      .wdata    (bus_wdata),
      .live     (chan_count[i*CW +: CW]),
      .rd_byte  (rd_bytes[i]),
      .load_val (chan_load_val[i*CW +: CW]),
      .load_stb (chan_load_stb[i]),
      .mode     (chan_mode[i*MW +: MW]),
      .bcd      (chan_bcd[i]),
      .mode_set (chan_mode_set[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (hit[i]) bus_rdata = rd_bytes[i];
  end

  // R2
  one_mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_mode_set));

  // R1
  one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_load_stb));
endmodule

// File: tb/timer_host_if_tb.sv
module timer_host_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_rdata;
  logic [47:0] chan_count;
  logic [47:0] chan_load_val;
  logic [2:0]  chan_load_stb, chan_bcd, chan_mode_set;
  logic [8:0]  chan_mode;
  logic [15:0] live [3];
  int tests = 0, fails = 0;

  int m_fmt[3], m_mode[3], m_bcd[3], m_wrhi[3], m_rdhi[3], m_lo[3];
  int m_lat[3], m_latv[3], m_lv[3], m_stb[3], m_ms[3];

  always #5 clk = ~clk;
  assign chan_count = {live[2], live[1], live[0]};

  timer_host_if u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .chan_count(chan_count), .chan_load_val(chan_load_val),
    .chan_load_stb(chan_load_stb), .chan_mode(chan_mode),
    .chan_bcd(chan_bcd), .chan_mode_set(chan_mode_set)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_fmt[i] = 3; m_mode[i] = 0; m_bcd[i] = 0; m_wrhi[i] = 0; m_rdhi[i] = 0;
      m_lo[i] = 0; m_lat[i] = 0; m_latv[i] = 0; m_lv[i] = 0; m_stb[i] = 0; m_ms[i] = 0;
    end
  endtask

  function automatic int ch_of(int a);
    return (a == 1) ? 0 : (a == 3) ? 1 : (a == 5) ? 2 : -1;
  endfunction

  function automatic int exp_rd(int a);
    int c = ch_of(a);
    int s;
    if (c < 0) return 0;
    s = m_latv[c] ? m_lat[c] : int'(live[c]);
    if (m_fmt[c] == 1) return s & 255;
    if (m_fmt[c] == 2) return (s >> 8) & 255;
    return m_rdhi[c] ? ((s >> 8) & 255) : (s & 255);
  endfunction

  task automatic step(string req, bit we, bit re, int a, int d);
    int c;
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = 3'(a); bus_wdata = 8'(d);
    for (int i = 0; i < 3; i++) live[i] = live[i] + 16'h0123 + 16'(i);
    #1;
    if (re) chk({req, " rdata"}, int'(bus_rdata), exp_rd(a));
    c = ch_of(a);
    for (int i = 0; i < 3; i++) begin m_stb[i] = 0; m_ms[i] = 0; end
    if (we && a == 7) begin
      int sel = (d >> 6) & 3, f = (d >> 4) & 3;
      if (sel < 3) begin
        if (f != 0) begin
          m_fmt[sel] = f; m_mode[sel] = (d >> 1) & 7; m_bcd[sel] = d & 1;
          m_wrhi[sel] = 0; m_rdhi[sel] = 0; m_latv[sel] = 0; m_ms[sel] = 1;
        end else if (!m_latv[sel]) begin
          m_lat[sel] = int'(live[sel]); m_latv[sel] = 1;
        end
      end
    end
    if (we && c >= 0) begin
      if (m_fmt[c] == 1) begin m_lv[c] = d; m_stb[c] = 1; end
      else if (m_fmt[c] == 2) begin m_lv[c] = d << 8; m_stb[c] = 1; end
      else if (!m_wrhi[c]) begin m_lo[c] = d; m_wrhi[c] = 1; end
      else begin m_lv[c] = (d << 8) | m_lo[c]; m_stb[c] = 1; m_wrhi[c] = 0; end
    end
    if (re && c >= 0) begin
      if (m_fmt[c] != 3 || m_rdhi[c]) m_latv[c] = 0;
      if (m_fmt[c] == 3) m_rdhi[c] = m_rdhi[c] ^ 1;
    end
    @(posedge clk); #1;
    bus_we = 0; bus_re = 0;
    for (int i = 0; i < 3; i++) begin
      chk({req, " load_stb"}, int'(chan_load_stb[i]), m_stb[i]);
      chk({req, " load_val"}, int'(chan_load_val[i*16 +: 16]), m_lv[i]);
      chk({req, " mode"}, int'(chan_mode[i*3 +: 3]), m_mode[i]);
      chk({req, " bcd"}, int'(chan_bcd[i]), m_bcd[i]);
      chk({req, " mode_set"}, int'(chan_mode_set[i]), m_ms[i]);
    end
  endtask

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) live[i] = 16'(16'h1000 * (i + 1));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R10 reset state
    step("R10", 0, 0, 0, 0);
    // R8 R10 default two-byte read on ch0
    step("R8", 0, 1, 1, 0);
    step("R8", 0, 1, 1, 0);
    // R3 R2 reprogram ch0: fmt1 mode2 -> 8'b00_01_010_0
    step("R3", 1, 0, 7, 8'h14);
    // R5 format-1 load
    step("R5", 1, 0, 1, 8'h5A);
    step("R8", 0, 1, 1, 0);
    // R6 ch1 fmt2 mode 3 bcd 1 -> 01_10_011_1
    step("R3", 1, 0, 7, 8'h67);
    step("R6", 1, 0, 3, 8'h01);
    step("R8", 0, 1, 3, 0);
    // R7 ch2 fmt3 mode5 -> 10_11_101_0
    step("R3", 1, 0, 7, 8'hBA);
    step("R7", 1, 0, 5, 8'h34);
    step("R7", 1, 0, 5, 8'h12);
    // R4 R9 latch ch2, live keeps moving
    step("R4", 1, 0, 7, 8'h80);
    step("R4", 0, 0, 0, 0);
    step("R4", 1, 0, 7, 8'h80);
    step("R9", 0, 1, 5, 0);
    step("R9", 0, 1, 5, 0);
    step("R9", 0, 1, 5, 0);
    step("R9", 0, 1, 5, 0);
    // R9 latch in single-byte format releases after one read
    step("R9", 1, 0, 7, 8'h40);
    step("R9", 0, 1, 3, 0);
    step("R9", 0, 1, 3, 0);
    // R2 select 3 ignored
    step("R2", 1, 0, 7, 8'hFF);
    step("R2", 1, 0, 7, 8'hC0);
    step("R2", 0, 1, 5, 0);
    // R1 other addresses
    step("R1", 1, 0, 0, 8'h33);
    step("R1", 1, 0, 2, 8'h44);
    step("R1", 1, 0, 6, 8'hFF);
    step("R1", 0, 1, 0, 0);
    step("R1", 0, 1, 6, 0);
    step("R1", 0, 1, 7, 0);
    // R3 reprogram mid-pair resets write order, drops latch
    step("R7", 1, 0, 5, 8'hAA);
    step("R4", 1, 0, 7, 8'h80);
    step("R3", 1, 0, 7, 8'hB0);
    step("R3", 1, 0, 5, 8'h78);
    step("R3", 1, 0, 5, 8'h56);
    step("R3", 0, 1, 5, 0);
    step("R3", 0, 1, 5, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule